// File: doc/BRIEF.md
# Multichannel Pulse Width Modulator with Shadowed Duty Updates

This block drives up to sixteen pulse outputs from a single shared time base. A prescaler divides the clock into ticks. A period counter advances once per tick and wraps at a programmable terminal value. Each channel holds two duty positions: a rise position, where its output goes high, and a fall position, where it goes low. All configuration arrives as single-cycle writes on a small address/data port. There is no read path.

Two build-time bit masks shape each channel. The shadow mask gives a channel a pair of holding registers in front of its active duty registers. While the runtime synchronous-update bit is set, writes to such a channel wait in the holding registers. They all move into the active registers together in the cycle that ends a period, so several channels can be retuned without a torn cycle. Channels without the holding pair always take a write at once.

The converter mask turns a channel into a low-ripple converter. Its rise register is then read as a level. A first-order accumulator adds that level every clock and sends the carry to the output. The result is a stream of one-clock pulses, spaced as evenly as possible, whose average equals level / 2^DW.

Top module: `pwm_bank`

## Requirements
- R1: While `rst` is high, every `pwm_out` bit is low, and the prescale, period, control, active duty, holding and accumulator registers are cleared to zero.
- R2: A prescale counter counts up by one per clock and returns to 0 in the cycle where its value is greater than or equal to the prescale register; that cycle is a tick. On each tick the period counter advances by one, or returns to 0 when its value is greater than or equal to the period register. `period_start` is high, combinationally, in exactly the cycles that are a tick with the period counter at or above the period register.
- R3: A PWM channel's output is registered. In the cycle after the period counter equals the channel's active rise value it is high, and in the cycle after it equals the active fall value it is low. Otherwise it holds its value.
- R4: A PWM channel whose active rise and fall values are equal drives low in the following cycle, whatever the counter value.
- R5: A channel outside the shadow mask uses a written duty value from the next cycle on, whatever the synchronous-update bit is.
- R6: A channel inside the shadow mask, with the synchronous-update bit clear, uses a written duty value from the next cycle on.
- R7: A channel inside the shadow mask, with the synchronous-update bit set, keeps its active rise and fall values unchanged except in the cycle after a `period_start` cycle. There it loads both from its holding registers, which hold the latest writes.
- R8: A channel inside the converter mask adds its active rise value to a DW-bit accumulator every clock, ignoring the prescaler, and outputs the carry one cycle later. Over any 2^DW consecutive cycles with a constant level, the output is high exactly level times.
- R9: A converter channel whose level stays at or below 2^(DW-1) never drives high in two consecutive cycles.
- R10: Address map: 0 = prescale (low PSW data bits), 1 = period, 2 = control (bit 0 = synchronous-update), 4+2c = rise of channel c, 5+2c = fall of channel c. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| pwm_out | output | NCH | Channel outputs |
| period_start | output | 1 | High in the last cycle of each period |

## Verification
The bench builds the block with NCH=4, DW=4, PSW=3 and AW=5. Channels 0 and 2 are shadowed, channel 1 is a plain PWM channel and channel 3 is a converter. One instance therefore holds every variant side by side. With a 4-bit counter, all 256 rise/fall pairs can be swept on two channel kinds at once, equal pairs included. All sixteen converter levels can be checked against their exact 16-cycle high count. A cycle-level arithmetic model compares every output in every cycle, across prescaled periods, synchronous updates timed at different phases of the period, and writes to unmapped addresses.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int unsigned ADDR_PRESCALE = 0;
   localparam int unsigned ADDR_PERIOD   = 1;
   localparam int unsigned ADDR_CONTROL  = 2;
   localparam int unsigned ADDR_CH_BASE  = 4;
   localparam int unsigned MAX_CHANNELS  = 16;

   function automatic int unsigned rise_addr(input int unsigned ch);
      return ADDR_CH_BASE + 2 * ch;
   endfunction

   function automatic int unsigned fall_addr(input int unsigned ch);
      return ADDR_CH_BASE + 2 * ch + 1;
   endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int unsigned DW  = 8,
   parameter int unsigned PSW = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [PSW-1:0] prescale,
   input  logic [DW-1:0]  period,
   output logic [DW-1:0]  cnt,
   output logic           period_start
);
   logic [PSW-1:0] pre_q;
   logic [DW-1:0]  cnt_q;
   logic           tick;
   logic           at_end;

   assign tick         = (pre_q >= prescale);
   assign at_end       = (cnt_q >= period);
   assign period_start = tick && at_end;
   assign cnt          = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         pre_q <= '0;
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_CNT_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q)); // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
      period_start |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/pwm_duty_store.sv
module pwm_duty_store #(
   parameter int unsigned DW       = 8,
   parameter bit          SHADOWED = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sync_en,
   input  logic          period_start,
   input  logic          wr_rise,
   input  logic          wr_fall,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rise_act,
   output logic [DW-1:0] fall_act
);
   logic [DW-1:0] rise_q;
   logic [DW-1:0] fall_q;

   assign rise_act = rise_q;
   assign fall_act = fall_q;

   if (SHADOWED) begin : g_shadow
      logic [DW-1:0] rise_hold_q;
      logic [DW-1:0] fall_hold_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            rise_hold_q <= '0;
            fall_hold_q <= '0;
            rise_q      <= '0;
            fall_q      <= '0;
         end else begin
            if (wr_rise) rise_hold_q <= wr_data;
            if (wr_fall) fall_hold_q <= wr_data;
            if (sync_en) begin
               if (period_start) begin
                  rise_q <= rise_hold_q;
                  fall_q <= fall_hold_q;
               end
            end else begin
               if (wr_rise) rise_q <= wr_data;
               if (wr_fall) fall_q <= wr_data;
            end
         end
      end

      AST_SYNC_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
         (sync_en && !period_start) |=> ($stable(rise_q) && $stable(fall_q))); // R7
      AST_SYNC_LOADS_AT_START: assert property (@(posedge clk) disable iff (rst)
         (sync_en && period_start) |=> (rise_q == $past(rise_hold_q))); // R7
      AST_ASYNC_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
         (!sync_en && wr_rise) |=> (rise_q == $past(wr_data))); // R6
   end else begin : g_direct
      logic unused_direct;
      assign unused_direct = sync_en ^ period_start;

      always_ff @(posedge clk) begin
         if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
         end else begin
            if (wr_rise) rise_q <= wr_data;
            if (wr_fall) fall_q <= wr_data;
         end
      end

      AST_DIRECT_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
         wr_fall |=> (fall_q == $past(wr_data))); // R5
   end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
   parameter int unsigned DW  = 8,
   parameter bit          DAC = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] cnt,
   input  logic [DW-1:0] rise,
   input  logic [DW-1:0] fall,
   output logic          out
);
   localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);

   logic out_q;
   assign out = out_q;

   if (DAC) begin : g_dac
      logic [DW-1:0] acc_q;
      logic [DW:0]   sum;
      logic          unused_dac;

      assign unused_dac = ^{cnt, fall};
      assign sum        = {1'b0, acc_q} + {1'b0, rise};

      always_ff @(posedge clk) begin
         if (rst) begin
            acc_q <= '0;
            out_q <= 1'b0;
         end else begin
            acc_q <= sum[DW-1:0];
            out_q <= sum[DW];
         end
      end

      AST_DAC_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
         (out_q && (rise <= HALF) && ($past(rise) <= HALF)) |=> !out_q); // R9
      AST_DAC_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
         (rise == '0) |=> !out_q); // R8
   end else begin : g_pwm
      always_ff @(posedge clk) begin
         if (rst) begin
            out_q <= 1'b0;
         end else if (rise == fall) begin
            out_q <= 1'b0;
         end else if (cnt == rise) begin
            out_q <= 1'b1;
         end else if (cnt == fall) begin
            out_q <= 1'b0;
         end
      end

      AST_EQUAL_POSITIONS_LOW: assert property (@(posedge clk) disable iff (rst)
         (rise == fall) |=> !out_q); // R4
      AST_RISE_SETS_HIGH: assert property (@(posedge clk) disable iff (rst)
         ((rise != fall) && (cnt == rise)) |=> out_q); // R3
      AST_FALL_SETS_LOW: assert property (@(posedge clk) disable iff (rst)
         ((rise != fall) && (cnt == fall)) |=> !out_q); // R3
   end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
   parameter int unsigned NCH         = 16,
   parameter int unsigned DW          = 8,
   parameter int unsigned PSW         = 8,
   parameter int unsigned AW          = 6,
   parameter logic [15:0] SHADOW_MASK = 16'h00FF,
   parameter logic [15:0] DAC_MASK    = 16'h8000
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   output logic [NCH-1:0] pwm_out,
   output logic           period_start
);
   localparam int unsigned LAST_ADDR = pwm_pkg::fall_addr(NCH - 1);

   initial begin : elab_checks
      assert (NCH >= 1 && NCH <= pwm_pkg::MAX_CHANNELS)
         else $error("pwm_bank: NCH must be 1..16");
      assert (DW >= 2) else $error("pwm_bank: DW must be at least 2");
      assert (PSW >= 1 && PSW <= DW) else $error("pwm_bank: PSW must be 1..DW");
      assert (LAST_ADDR < (1 << AW)) else $error("pwm_bank: AW too small for NCH");
   end

   logic [PSW-1:0] prescale_q;
   logic [DW-1:0]  period_q;
   logic           sync_q;
   logic [DW-1:0]  cnt;
   logic           pstart;

   always_ff @(posedge clk) begin
      if (rst) begin
         prescale_q <= '0;
         period_q   <= '0;
         sync_q     <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == AW'(pwm_pkg::ADDR_PRESCALE)) prescale_q <= wr_data[PSW-1:0];
         if (wr_addr == AW'(pwm_pkg::ADDR_PERIOD))   period_q   <= wr_data;
         if (wr_addr == AW'(pwm_pkg::ADDR_CONTROL))  sync_q     <= wr_data[0];
      end
   end

   pwm_timebase #(.DW(DW), .PSW(PSW)) u_timebase (
      .clk          (clk),
      .rst          (rst),
      .prescale     (prescale_q),
      .period       (period_q),
      .cnt          (cnt),
      .period_start (pstart)
   );

   assign period_start = pstart;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic          wr_rise;
      logic          wr_fall;
      logic [DW-1:0] rise_act;
      logic [DW-1:0] fall_act;

      assign wr_rise = wr_en && (wr_addr == AW'(pwm_pkg::rise_addr(c)));
      assign wr_fall = wr_en && (wr_addr == AW'(pwm_pkg::fall_addr(c)));

      pwm_duty_store #(.DW(DW), .SHADOWED(SHADOW_MASK[c])) u_store (
         .clk          (clk),
         .rst          (rst),
         .sync_en      (sync_q),
         .period_start (pstart),
         .wr_rise      (wr_rise),
         .wr_fall      (wr_fall),
         .wr_data      (wr_data),
         .rise_act     (rise_act),
         .fall_act     (fall_act)
      );

      pwm_wave #(.DW(DW), .DAC(DAC_MASK[c])) u_wave (
         .clk  (clk),
         .rst  (rst),
         .cnt  (cnt),
         .rise (rise_act),
         .fall (fall_act),
         .out  (pwm_out[c])
      );
   end

   AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
      rst |=> (pwm_out == '0)); // R1
   AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr > AW'(LAST_ADDR))) |=>
         ($stable(prescale_q) && $stable(period_q) && $stable(sync_q))); // R10
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
   localparam int NCH = 4;
   localparam int DW  = 4;
   localparam int PSW = 3;
   localparam int AW  = 5;
   localparam logic [15:0] SHM = 16'h0005;
   localparam logic [15:0] DCM = 16'h0008;
   localparam int FULL = 1 << DW;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [NCH-1:0] pwm_out;
   logic           period_start;

   int vectors = 0;
   int miscompares = 0;
   bit chk_en = 1'b0;
   bit done = 1'b0;
   string phase_tag = "";

   // reference model state
   int m_pre_reg, m_per_reg, m_sync, m_pc, m_cnt;
   int m_sr[NCH], m_sf[NCH], m_ar[NCH], m_af[NCH], m_acc[NCH];
   bit m_out[NCH];

   always #2.5 clk = ~clk;

   pwm_bank #(.NCH(NCH), .DW(DW), .PSW(PSW), .AW(AW),
              .SHADOW_MASK(SHM), .DAC_MASK(DCM)) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out), .period_start(period_start)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_pre_reg = 0; m_per_reg = 0; m_sync = 0; m_pc = 0; m_cnt = 0;
         for (int c = 0; c < NCH; c++) begin
            m_sr[c] = 0; m_sf[c] = 0; m_ar[c] = 0; m_af[c] = 0;
            m_acc[c] = 0; m_out[c] = 1'b0;
         end
      end else begin
         bit tick, ps;
         int a, d;
         a = int'(wr_addr);
         d = int'(wr_data);
         tick = (m_pc >= m_pre_reg);
         ps = tick && (m_cnt >= m_per_reg);
         for (int c = 0; c < NCH; c++) begin
            if (DCM[c]) begin
               int s;
               s = m_acc[c] + m_ar[c];
               m_out[c] = (s >= FULL);
               m_acc[c] = s % FULL;
            end else if (m_ar[c] == m_af[c]) m_out[c] = 1'b0;
            else if (m_cnt == m_ar[c]) m_out[c] = 1'b1;
            else if (m_cnt == m_af[c]) m_out[c] = 1'b0;
         end
         for (int c = 0; c < NCH; c++) begin
            bit wr_r, wr_f;
            wr_r = wr_en && (a == 4 + 2 * c);
            wr_f = wr_en && (a == 5 + 2 * c);
            if (SHM[c]) begin
               if (m_sync != 0 && ps) begin
                  m_ar[c] = m_sr[c];
                  m_af[c] = m_sf[c];
               end
               if (wr_r) begin m_sr[c] = d; if (m_sync == 0) m_ar[c] = d; end
               if (wr_f) begin m_sf[c] = d; if (m_sync == 0) m_af[c] = d; end
            end else begin
               if (wr_r) m_ar[c] = d;
               if (wr_f) m_af[c] = d;
            end
         end
         if (tick) begin
            m_pc = 0;
            m_cnt = (m_cnt >= m_per_reg) ? 0 : m_cnt + 1;
         end else m_pc = m_pc + 1;
         if (wr_en && a == 0) m_pre_reg = d % (1 << PSW);
         if (wr_en && a == 1) m_per_reg = d;
         if (wr_en && a == 2) m_sync = d % 2;
      end
   end

   function automatic string tag_of(input int c);
      if (phase_tag != "") return phase_tag;
      if (DCM[c]) return "R8";
      if (SHM[c]) return (m_sync != 0) ? "R7" : "R6";
      return "R3";
   endfunction

   // continuous per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (chk_en && !done) begin
         bit exp_ps;
         exp_ps = (m_pc >= m_pre_reg) && (m_cnt >= m_per_reg);
         vectors++;
         if (period_start !== exp_ps) begin
            miscompares++;
            $display("FAIL R2 period_start got %0b exp %0b at %0t", period_start, exp_ps, $time);
         end
         for (int c = 0; c < NCH; c++) begin
            vectors++;
            if (pwm_out[c] !== m_out[c]) begin
               miscompares++;
               $display("FAIL %s ch%0d got %0b exp %0b at %0t", tag_of(c), c, pwm_out[c], m_out[c], $time);
            end
         end
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stimulus
      // R1: outputs low during reset
      phase_tag = "R1";
      repeat (2) @(negedge clk);
      chk_en = 1'b1;
      idle(3);
      @(negedge clk); rst = 1'b0;
      phase_tag = "";

      // R2 timebase, R3/R4 exhaustive pairs on plain ch1, R6 on shadowed ch0
      wr(0, 0);
      wr(1, 15);
      for (int r = 0; r < FULL; r++) begin
         for (int f = 0; f < FULL; f++) begin
            wr(6, r); wr(7, f);   // ch1: R5 immediate
            wr(4, f); wr(5, r);   // ch0: R6 immediate with sync off
            idle(18);
         end
      end

      // R2 with prescaling
      wr(0, 3); wr(1, 6);
      for (int k = 0; k < 6; k++) begin
         wr(8, k); wr(9, (k + 3) % 7);
         wr(6, 6 - k); wr(7, k);
         idle(60);
      end

      // R7 synchronous updates written at varied phases
      wr(0, 0); wr(1, 11);
      wr(2, 1);
      for (int k = 0; k < 24; k++) begin
         idle(k % 7);
         wr(4, (k * 3) % 12); wr(5, (k * 5 + 2) % 12);
         idle((k * 2) % 5);
         wr(8, (k + 1) % 12); wr(9, (k * 7) % 12);
         wr(6, k % 12);       // R5: plain channel still immediate
         idle(14);
      end
      wr(0, 2);
      for (int k = 0; k < 6; k++) begin
         wr(4, k); wr(5, k + 4);
         idle(50);
      end
      wr(2, 0);
      idle(20);
      wr(0, 0);

      // R8 / R9 converter sweep on ch3
      for (int lv = 0; lv < FULL; lv++) begin
         int highs;
         bit prev, adj;
         wr(10, lv);
         idle(3);
         highs = 0; prev = 1'b0; adj = 1'b0;
         for (int i = 0; i < FULL; i++) begin
            @(negedge clk);
            if (pwm_out[3]) highs++;
            if (pwm_out[3] && prev) adj = 1'b1;
            prev = pwm_out[3];
         end
         vectors++;
         if (highs != lv) begin
            miscompares++;
            $display("FAIL R8 level %0d got %0d highs exp %0d", lv, highs, lv);
         end
         if (lv <= FULL / 2) begin
            vectors++;
            if (adj) begin
               miscompares++;
               $display("FAIL R9 level %0d got adjacent highs exp none", lv);
            end
         end
      end

      // R10 unmapped addresses leave everything unchanged
      phase_tag = "R10";
      wr(1, 9);
      wr(6, 2); wr(7, 7);
      idle(20);
      wr(3, 15);
      for (int a = 12; a < 32; a++) wr(a, 15 - (a % 16));
      idle(40);

      // R1 again: reset mid-run
      phase_tag = "R1";
      @(negedge clk); rst = 1'b1;
      idle(4);
      @(negedge clk); rst = 1'b0;
      idle(10);
      finish_run();
   end
endmodule